// File: doc/BRIEF.md
# DPLL Phase Lock and Loss Indicator

This block sits beside the phase detector of a digital PLL and turns the stream of signed phase-error samples into two status flags: phase-locked and phase-lost. One error sample is taken on every clock. A sample whose magnitude falls outside a programmable acceptance window raises loss on the next clock. Lock is granted only after the error has stayed inside the window across two pulses of a once-per-second tick. That gives a qualification time of one to two seconds. Between the two states the block reports "acquiring", with both flags low.

An 8-bit configuration byte, written through a simple write strobe, holds four fields. Two are option bits: one turns the window check on, and the other makes a missing reference count as loss. The byte also carries a test bit that is kept but has no effect, and a 3-bit window code. The window half-width is the code times one eighth of a half cycle, so the window scales in proportion to the code. Code 0 is not a valid window. Loss detected by other detectors elsewhere in the PLL arrives on a separate input and always forces loss.

Top module: `phase_lock_monitor`

## Requirements
- R1: Out of reset, lock is 0 and loss is 1. The configuration byte resets to 0xA2: window check enabled (bit 7 = 1), no-activity loss off (bit 6 = 0), test bit set (bit 5 = 1), window code 2 (bits 2:0).
- R2: The phase error is a signed 12-bit two's-complement value in which 2048 counts equal 180 degrees. With the window check enabled, a sample whose absolute value exceeds code x 256 sets loss and clears lock on the next clock. A value equal to the threshold counts as inside the window.
- R3: Lock rises on the clock that samples the second tick pulse seen with no loss condition present. Ticks are counted since the last loss condition, code change or reset.
- R4: With the window check enabled and window code 0, loss stays 1 and lock stays 0 whatever the phase error and tick inputs do.
- R5: With the window check disabled (bit 7 = 0), the phase error has no effect on either flag.
- R6: With bit 6 clear, a low reference-activity input has no effect. With bit 6 set, a low reference-activity input sets loss and clears lock on the next clock.
- R7: A high external-loss input sets loss and clears lock on the next clock, whatever the configuration.
- R8: Lock and loss are never 1 together. Loss returns to 0 on the clock after every loss condition has gone.
- R9: A configuration write takes effect from the clock after the write strobe. A write that changes the window code clears lock and restarts the tick count. A write that leaves the code unchanged does not disturb lock.
- R10: Bit 5 and bits 4:3 of the configuration byte have no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_err | input | 12 | Signed phase error sample, taken every clock |
| ref_active | input | 1 | High while the reference shows activity |
| tick_1s | input | 1 | One-clock pulse once per second |
| ext_loss | input | 1 | Loss condition from other detectors |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to write |
| lock | output | 1 | Phase-locked flag (registered) |
| loss | output | 1 | Phase-lost flag (registered) |

## Verification
The hardest situation to reach from the ports is a change of window code while the block is already locked, combined with a write that keeps the code the same but alters the test bit and the unused bits. Both writes need the error to have stayed in the window across two tick pulses first. The directed part of the stimulus therefore holds the error inside the window and pulses the tick twice before each such write. The random part keeps the error mostly small and pulses ticks at a low rate, so that long lock intervals occur and are broken by rare excursions, external loss, inactivity and occasional configuration writes.

// File: rtl/phlk_pkg.sv
package phlk_pkg;

   localparam int CFG_W  = 8;
   localparam int CODE_W = 3;

   // Configuration byte layout (bit 7 down to bit 0)
   typedef struct packed {
      logic              chk_en;      // window comparison enable
      logic              noact_loss;  // inactivity counts as loss
      logic              test_bit;    // kept, no effect
      logic [1:0]        spare;       // kept, no effect
      logic [CODE_W-1:0] win_code;    // window size code
   } phlk_cfg_t;

endpackage

// File: rtl/phlk_cfg_reg.sv
module phlk_cfg_reg
   import phlk_pkg::*;
#(
   parameter logic [CFG_W-1:0] RESET_VAL = 8'hA2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output phlk_cfg_t        cfg_o,
   output logic             code_change_o
);

   phlk_cfg_t cfg_q;
   phlk_cfg_t wr_cfg;

   assign wr_cfg = phlk_cfg_t'(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= phlk_cfg_t'(RESET_VAL);
      end else if (we) begin
         cfg_q <= wr_cfg;
      end
   end

   assign cfg_o         = cfg_q;
   assign code_change_o = we && (wr_cfg.win_code != cfg_q.win_code);

endmodule

// File: rtl/phlk_window.sv
module phlk_window
   import phlk_pkg::*;
#(
   parameter int ERR_W          = 12,
   parameter int STEP_SHIFT     = 8,
   parameter bit INCLUSIVE_EDGE = 1'b1
) (
   input  logic signed [ERR_W-1:0]  err_i,
   input  logic        [CODE_W-1:0] code_i,
   output logic                     outside_o,
   output logic                     code_zero_o
);

   localparam int THR_W = ERR_W + 1;

   logic [ERR_W-1:0] mag;
   logic [THR_W-1:0] mag_x;
   logic [THR_W-1:0] thr;

   // |err| ; the most negative value maps to 2^(ERR_W-1) as unsigned
   assign mag   = err_i[ERR_W-1] ? (~err_i + 1'b1) : err_i;
   assign mag_x = {1'b0, mag};
   assign thr   = THR_W'(code_i) << STEP_SHIFT;

   generate
      if (INCLUSIVE_EDGE) begin : g_incl
         assign outside_o = mag_x > thr;
      end else begin : g_excl
         assign outside_o = mag_x >= thr;
      end
   endgenerate

   assign code_zero_o = (code_i == '0);

endmodule

// File: rtl/phlk_dwell.sv
module phlk_dwell #(
   parameter int DWELL_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic tick_i,
   output logic lock_o
);

   localparam int CNT_W = (DWELL_TICKS < 2) ? 1 : $clog2(DWELL_TICKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lock_q <= 1'b0;
      end else if (clear_i) begin
         cnt_q  <= '0;
         lock_q <= 1'b0;
      end else if (tick_i && !lock_q) begin
         if (cnt_q == LAST) begin
            lock_q <= 1'b1;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign lock_o = lock_q;

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
   import phlk_pkg::*;
#(
   parameter int               ERR_W          = 12,
   parameter int               STEP_SHIFT     = 8,
   parameter int               DWELL_TICKS    = 2,
   parameter bit               INCLUSIVE_EDGE = 1'b1,
   parameter logic [CFG_W-1:0] CFG_RESET      = 8'hA2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [ERR_W-1:0] phase_err,
   input  logic                    ref_active,
   input  logic                    tick_1s,
   input  logic                    ext_loss,
   input  logic                    cfg_we,
   input  logic [CFG_W-1:0]        cfg_wdata,
   output logic                    lock,
   output logic                    loss
);

   localparam int MAX_THR  = ((1 << CODE_W) - 1) << STEP_SHIFT;
   localparam int HALF_CYC = 1 << (ERR_W - 1);

   generate
      if (ERR_W < 4) begin : g_bad_err_w
         $error("phase_lock_monitor: ERR_W too small");
      end
      if (MAX_THR > HALF_CYC) begin : g_bad_step
         $error("phase_lock_monitor: widest window exceeds half a cycle");
      end
      if (DWELL_TICKS < 1) begin : g_bad_dwell
         $error("phase_lock_monitor: DWELL_TICKS must be at least 1");
      end
   endgenerate

   phlk_cfg_t cfg_q;
   logic      code_change;
   logic      win_outside;
   logic      win_code_zero;
   logic      win_loss;
   logic      noact_trip;
   logic      loss_cond;
   logic      dwell_clear;
   logic      loss_q;
   logic      unused_cfg_bits;

   phlk_cfg_reg #(
      .RESET_VAL (CFG_RESET)
   ) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .we            (cfg_we),
      .wdata         (cfg_wdata),
      .cfg_o         (cfg_q),
      .code_change_o (code_change)
   );

   phlk_window #(
      .ERR_W          (ERR_W),
      .STEP_SHIFT     (STEP_SHIFT),
      .INCLUSIVE_EDGE (INCLUSIVE_EDGE)
   ) u_win (
      .err_i       (phase_err),
      .code_i      (cfg_q.win_code),
      .outside_o   (win_outside),
      .code_zero_o (win_code_zero)
   );

   assign win_loss    = cfg_q.chk_en && (win_code_zero || win_outside);
   assign noact_trip  = cfg_q.noact_loss && !ref_active;
   assign loss_cond   = win_loss || noact_trip || ext_loss;
   assign dwell_clear = loss_cond || code_change;

   phlk_dwell #(
      .DWELL_TICKS (DWELL_TICKS)
   ) u_dwell (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (dwell_clear),
      .tick_i  (tick_1s),
      .lock_o  (lock)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loss_q <= 1'b1;
      end else begin
         loss_q <= loss_cond;
      end
   end

   assign loss = loss_q;

   assign unused_cfg_bits = ^{cfg_q.test_bit, cfg_q.spare};

endmodule

// File: rtl/phlk_checker.sv
module phlk_checker
   import phlk_pkg::*;
#(
   parameter int ERR_W      = 12,
   parameter int STEP_SHIFT = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [ERR_W-1:0] phase_err,
   input logic                    ref_active,
   input logic                    tick_1s,
   input logic                    ext_loss,
   input logic                    cfg_we,
   input logic [CFG_W-1:0]        cfg_wdata,
   input phlk_cfg_t               cfg,
   input logic                    lock,
   input logic                    loss
);

   logic [ERR_W:0] abs_err;
   logic [ERR_W:0] limit;

   assign abs_err = phase_err[ERR_W-1] ? (ERR_W+1)'(-$signed({phase_err[ERR_W-1], phase_err}))
                                       : (ERR_W+1)'(phase_err);
   assign limit   = (ERR_W+1)'(cfg.win_code) << STEP_SHIFT;

   AST_LOCK_LOSS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock && loss)); // R8

   AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.chk_en && abs_err > limit) |=> (loss && !lock)); // R2

   AST_LOCK_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> $past(tick_1s)); // R3

   AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.chk_en && cfg.win_code == '0) |=> (loss && !lock)); // R4

   AST_NOACT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.noact_loss && !ref_active) |=> (loss && !lock)); // R6

   AST_EXT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      ext_loss |=> (loss && !lock)); // R7

   AST_CODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[CODE_W-1:0] != cfg.win_code) |=> !lock); // R9

endmodule

bind phase_lock_monitor phlk_checker #(
   .ERR_W      (ERR_W),
   .STEP_SHIFT (STEP_SHIFT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase_err  (phase_err),
   .ref_active (ref_active),
   .tick_1s    (tick_1s),
   .ext_loss   (ext_loss),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg        (cfg_q),
   .lock       (lock),
   .loss       (loss)
);

// File: tb/sim_phase_lock_monitor.sv
`timescale 1ns/1ps
module sim_phase_lock_monitor;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [11:0] phase_err = '0;
   logic               ref_active = 1'b1;
   logic               tick_1s = 1'b0;
   logic               ext_loss = 1'b0;
   logic               cfg_we = 1'b0;
   logic [7:0]         cfg_wdata = '0;
   logic               lock;
   logic               loss;

   int n_checks = 0;
   int n_errors = 0;

   // reference model state
   logic [7:0] m_cfg  = 8'hA2;
   int         m_cnt  = 0;
   bit         m_lock = 1'b0;
   bit         m_loss = 1'b1;

   always #2.5 clk = ~clk;

   phase_lock_monitor u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_err  (phase_err),
      .ref_active (ref_active),
      .tick_1s    (tick_1s),
      .ext_loss   (ext_loss),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .lock       (lock),
      .loss       (loss)
   );

   function automatic bit exp_loss_cond(logic [7:0] c, int e, bit act, bit ext);
      int thr;
      int mag;
      thr = int'(c[2:0]) * 256;
      mag = (e < 0) ? -e : e;
      return ext || (c[6] && !act) || (c[7] && (c[2:0] == 3'd0 || mag > thr));
   endfunction

   task automatic check(string req, string what, int act_v, int exp_v);
      n_checks++;
      if (act_v != exp_v) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
      end
   endtask

   // one clock: drive at negedge, advance model, compare after posedge
   task automatic step(int e, bit act, bit tk, bit ext, bit we, logic [7:0] wd,
                       string req_loss, string req_lock);
      bit lc;
      bit chg;
      @(negedge clk);
      phase_err  = 12'(e);
      ref_active = act;
      tick_1s    = tk;
      ext_loss   = ext;
      cfg_we     = we;
      cfg_wdata  = wd;
      lc  = exp_loss_cond(m_cfg, e, act, ext);
      chg = we && (wd[2:0] != m_cfg[2:0]);
      if (lc || chg) begin
         m_cnt  = 0;
         m_lock = 1'b0;
      end else if (tk && !m_lock) begin
         m_cnt++;
         if (m_cnt == 2) begin
            m_lock = 1'b1;
            m_cnt  = 0;
         end
      end
      m_loss = lc;
      if (we) m_cfg = wd;
      @(posedge clk);
      #1;
      check(req_loss, "loss", int'(loss), int'(m_loss));
      check(req_lock, "lock", int'(lock), int'(m_lock));
      check("R8", "exclusive", int'(lock && loss), 0);
   endtask

   task automatic idle(int e, int n, string rq);
      for (int i = 0; i < n; i++) step(e, 1, 0, 0, 0, 8'h00, rq, rq);
   endtask

   task automatic tick(int e, string rq);
      step(e, 1, 1, 0, 0, 8'h00, rq, rq);
   endtask

   task automatic wr(logic [7:0] d, string rq);
      step(0, 1, 0, 0, 1, d, rq, rq);
   endtask

   initial begin
      #(200000 * 5);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      check("R1", "reset loss", int'(loss), 1);
      check("R1", "reset lock", int'(lock), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R3: default config, acquire lock with error at 0
      idle(0, 2, "R8");
      tick(0, "R3");
      idle(0, 3, "R3");
      tick(0, "R3");
      check("R3", "locked after two ticks", int'(lock), 1);

      // R2: window edge for default code 2 (threshold 512)
      idle(512, 2, "R2");
      idle(513, 1, "R2");
      check("R2", "loss at 513", int'(loss), 1);
      tick(-512, "R2");
      tick(-512, "R2");
      idle(-513, 1, "R2");
      idle(-2048, 1, "R2");
      idle(0, 1, "R8");

      // R7: external loss
      tick(0, "R7");
      tick(0, "R7");
      step(0, 1, 0, 1, 0, 8'h00, "R7", "R7");
      check("R7", "ext loss", int'(loss), 1);

      // R6: inactivity ignored, then enabled
      step(0, 0, 1, 0, 0, 8'h00, "R6", "R6");
      step(0, 0, 1, 0, 0, 8'h00, "R6", "R6");
      check("R6", "inactive ignored", int'(lock), 1);
      wr(8'hE2, "R9");
      step(0, 0, 0, 0, 0, 8'h00, "R6", "R6");
      check("R6", "inactive loss", int'(loss), 1);
      idle(0, 1, "R6");

      // R4: code 0 forces loss
      wr(8'h80, "R9");
      for (int i = 0; i < 4; i++) tick(0, "R4");
      check("R4", "code0 loss", int'(loss), 1);

      // R5: window check off
      wr(8'h02, "R5");
      tick(2047, "R5");
      tick(-2048, "R5");
      check("R5", "lock with big error", int'(lock), 1);

      // R9 / R10: same-code write keeps lock, code change drops it
      wr(8'h82, "R9");
      wr(8'hBA, "R10");
      check("R10", "lock kept", int'(lock), 1);
      idle(700, 1, "R2");
      wr(8'h83, "R9");
      idle(700, 1, "R9");
      tick(700, "R9");
      tick(700, "R9");
      check("R9", "wider code lock", int'(lock), 1);
      wr(8'h84, "R9");
      check("R9", "code change drop", int'(lock), 0);
      wr(8'hA2, "R9");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int  e;
         bit  act, tk, ext, we;
         logic [7:0] wd;
         if ($urandom_range(0, 9) < 8) e = int'($urandom_range(0, 1100)) - 550;
         else e = int'($urandom_range(0, 4095)) - 2048;
         act = ($urandom_range(0, 39) != 0);
         tk  = ($urandom_range(0, 7) == 0);
         ext = ($urandom_range(0, 79) == 0);
         we  = ($urandom_range(0, 149) == 0);
         wd  = 8'($urandom_range(0, 255));
         if (wd[2:0] == 3'd0 && $urandom_range(0, 3) != 0) wd[1] = 1'b1;
         step(e, act, tk, ext, we, wd, "R2", "R3");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule